// File: doc/BRIEF.md
# Power-Cycling ADC Host Sequencer

This block sits on the host side of a parallel-output successive-approximation converter and drives it through one sample per period while keeping it powered down between samples. A free-running period counter issues a sample tick. On each tick the sequencer takes the converter out of standby and waits a fixed settling window. It then raises the conversion-start line, watches the converter's status line for the end of conversion, and reads the result with a chip-select/read-strobe cycle. After the read it puts the converter back into standby and holds a quiet gap before it returns to idle.

Every delay is a parameter counted in system-clock cycles. The configured period is raised to the shortest period that fits a full sequence, including the timeout bound. A mode parameter chooses between two ways of signalling completion. In busy mode the start line stays high until completion, and completion is a falling status edge. In end-of-conversion mode the start line is only a pulse, and completion is the rising edge that ends a low status pulse. If completion never arrives, a timeout raises an error strobe and the converter goes back to standby without a read.

Top module: `adc_pwr_sequencer`

## Requirements
- R1: While rstN is low and on the first cycle after it, wakeOut=0, convst=0, csN=1, rdN=1, resultValid=0 and errorPulse=0.
- R2: A sample tick occurs every PERIOD_CYC cycles, the first at the PERIOD_CYC-th rising edge after reset. A tick seen in idle raises wakeOut on the next cycle, and convst is never high unless wakeOut is high.
- R3: convst rises exactly WAKE_CYC cycles after wakeOut rises and stays high for at least PULSE_CYC cycles.
- R4: With EOC_MODE=0, convst stays high from its rising edge until completion, and completion is a 1-to-0 transition of statusLine seen after the start pulse.
- R5: With EOC_MODE=1, convst falls after exactly PULSE_CYC cycles, and completion is a 0-to-1 transition of statusLine (the end of a low status pulse).
- R6: The cycle after completion is detected, csN and rdN go low together for exactly RD_CYC cycles. rdN is never low while convst is high.
- R7: The converter word present on dataIn during the ACCESS_CYC-th cycle of rdN low is presented on resultData with resultValid high for exactly one cycle, on the cycle after that one.
- R8: When the read ends, wakeOut goes low on the same cycle rdN rises. At least QUIET_CYC cycles pass between the end of a read and the next rising edge of convst.
- R9: If no completion is detected within TIMEOUT_CYC cycles after the start pulse, errorPulse is high for one cycle and wakeOut is low in that cycle. No read takes place and no result is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| statusLine | input | 1 | Converter busy / end-of-conversion status |
| dataIn | input | DATA_W | Converter parallel data bus |
| wakeOut | output | 1 | High takes the converter out of standby |
| convst | output | 1 | Conversion start, rising edge starts a conversion |
| csN | output | 1 | Active-low chip select |
| rdN | output | 1 | Active-low read strobe |
| resultValid | output | 1 | One-cycle strobe for a new result |
| resultData | output | DATA_W | Captured converter word |
| errorPulse | output | 1 | One-cycle strobe on conversion timeout |

## Verification
The properties assume that statusLine and dataIn are already synchronous to clk. They also assume the converter changes statusLine only in response to a start edge, so a stray completion edge cannot arrive outside the conversion window. The stimulus meets these assumptions with a converter model clocked on the same edge. That model moves its status line only after it sees convst rise, and it keeps every conversion it completes shorter than the timeout. It places a valid word on the bus only after the read strobe has been low for the access time and drives the complemented word before that, so an early capture shows up as a wrong result. It also leaves selected conversions unanswered to exercise the timeout.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_START,
    ST_CONV,
    ST_READ,
    ST_QUIET
  } seqState_t;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic capture;
    logic fault;
  } seqStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int DATA_W     = 14,
  parameter int PERIOD_CYC = 600,
  parameter int PER_W      = 10,
  parameter bit EOC_MODE   = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              statusLine,
  input  logic [DATA_W-1:0] dataIn,
  input  seqStrobe_t        strobe,
  output logic              tick,
  output logic              doneEdge,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultData,
  output logic              errorPulse
);

  logic [PER_W-1:0] periodCnt;
  logic             statusQ;

  assign tick = (periodCnt == PER_W'(PERIOD_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt   <= '0;
      statusQ     <= EOC_MODE;
      resultValid <= 1'b0;
      resultData  <= '0;
      errorPulse  <= 1'b0;
    end else begin
      periodCnt   <= tick ? '0 : periodCnt + PER_W'(1);
      statusQ     <= statusLine;
      resultValid <= strobe.capture;
      errorPulse  <= strobe.fault;
      if (strobe.capture) begin
        resultData <= dataIn;
      end
    end
  end

  // completion edge polarity follows the operating mode
  if (EOC_MODE) begin : g_eocEdge
    assign doneEdge = ~statusQ & statusLine;
  end else begin : g_busyEdge
    assign doneEdge = statusQ & ~statusLine;
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int WAKE_CYC    = 200,
  parameter int PULSE_CYC   = 3,
  parameter int TIMEOUT_CYC = 300,
  parameter int RD_CYC      = 5,
  parameter int ACCESS_CYC  = 4,
  parameter int QUIET_CYC   = 15,
  parameter bit EOC_MODE    = 1'b0,
  parameter int CNT_W       = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       doneEdge,
  output logic       wakeOut,
  output logic       convst,
  output logic       csN,
  output logic       rdN,
  output seqStrobe_t strobe
);

  seqState_t        state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt + CNT_W'(1);
    strobe   = '0;
    unique case (state)
      ST_IDLE: begin
        cntNxt = '0;
        if (tick) stateNxt = ST_WAKE;
      end
      ST_WAKE: begin
        if (cnt == CNT_W'(WAKE_CYC - 1)) begin
          stateNxt = ST_START;
          cntNxt   = '0;
        end
      end
      ST_START: begin
        if (cnt == CNT_W'(PULSE_CYC - 1)) begin
          stateNxt = ST_CONV;
          cntNxt   = '0;
        end
      end
      ST_CONV: begin
        if (doneEdge) begin
          stateNxt = ST_READ;
          cntNxt   = '0;
        end else if (cnt == CNT_W'(TIMEOUT_CYC - 1)) begin
          stateNxt     = ST_IDLE;
          cntNxt       = '0;
          strobe.fault = 1'b1;
        end
      end
      ST_READ: begin
        strobe.capture = (cnt == CNT_W'(ACCESS_CYC - 1));
        if (cnt == CNT_W'(RD_CYC - 1)) begin
          stateNxt = ST_QUIET;
          cntNxt   = '0;
        end
      end
      ST_QUIET: begin
        if (cnt == CNT_W'(QUIET_CYC - 1)) begin
          stateNxt = ST_IDLE;
          cntNxt   = '0;
        end
      end
      default: begin
        stateNxt = ST_IDLE;
        cntNxt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  assign wakeOut = (state == ST_WAKE) || (state == ST_START) ||
                   (state == ST_CONV) || (state == ST_READ);
  assign convst  = (state == ST_START) || ((state == ST_CONV) && !EOC_MODE);
  assign csN     = (state != ST_READ);
  assign rdN     = (state != ST_READ);

endmodule

// File: rtl/adc_pwr_sequencer.sv
module adc_pwr_sequencer
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int PERIOD_CYC  = 600,
  parameter int WAKE_CYC    = 200,
  parameter int PULSE_CYC   = 3,
  parameter int TIMEOUT_CYC = 300,
  parameter int RD_CYC      = 5,
  parameter int ACCESS_CYC  = 4,
  parameter int QUIET_CYC   = 15,
  parameter bit EOC_MODE    = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              statusLine,
  input  logic [DATA_W-1:0] dataIn,
  output logic              wakeOut,
  output logic              convst,
  output logic              csN,
  output logic              rdN,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultData,
  output logic              errorPulse
);

  // the read strobe is never shorter than the access time
  localparam int RD_EFF     = maxOf(RD_CYC, ACCESS_CYC);
  // shortest period that fits wake, start, worst-case wait, read and quiet
  localparam int MIN_PERIOD = WAKE_CYC + PULSE_CYC + TIMEOUT_CYC + RD_EFF + QUIET_CYC + 1;
  localparam int PERIOD_EFF = maxOf(PERIOD_CYC, MIN_PERIOD);
  localparam int CNT_MAX    = maxOf(maxOf(WAKE_CYC, TIMEOUT_CYC),
                                    maxOf(maxOf(PULSE_CYC, RD_EFF), QUIET_CYC));
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam int PER_W      = $clog2(PERIOD_EFF + 1);

  seqStrobe_t strobe;
  logic       tick;
  logic       doneEdge;

  adc_seq_ctrl #(
    .WAKE_CYC   (WAKE_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .RD_CYC     (RD_EFF),
    .ACCESS_CYC (ACCESS_CYC),
    .QUIET_CYC  (QUIET_CYC),
    .EOC_MODE   (EOC_MODE),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .doneEdge(doneEdge),
    .wakeOut (wakeOut),
    .convst  (convst),
    .csN     (csN),
    .rdN     (rdN),
    .strobe  (strobe)
  );

  adc_seq_datapath #(
    .DATA_W    (DATA_W),
    .PERIOD_CYC(PERIOD_EFF),
    .PER_W     (PER_W),
    .EOC_MODE  (EOC_MODE)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .statusLine (statusLine),
    .dataIn     (dataIn),
    .strobe     (strobe),
    .tick       (tick),
    .doneEdge   (doneEdge),
    .resultValid(resultValid),
    .resultData (resultData),
    .errorPulse (errorPulse)
  );

endmodule

// File: rtl/adc_pwr_sequencer_chk.sv
module adc_pwr_sequencer_chk #(
  parameter int WAKE_CYC  = 200,
  parameter int RD_CYC    = 5,
  parameter int QUIET_CYC = 15
) (
  input logic clk,
  input logic rstN,
  input logic wakeOut,
  input logic convst,
  input logic csN,
  input logic rdN,
  input logic resultValid,
  input logic errorPulse
);

  logic [15:0] wakeRun;
  logic [15:0] rdLowRun;
  logic [15:0] sinceRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeRun   <= '0;
      rdLowRun  <= '0;
      sinceRead <= 16'hFFFF;
    end else begin
      wakeRun   <= !wakeOut ? '0 : ((wakeRun == 16'hFFFF) ? wakeRun : wakeRun + 16'd1);
      rdLowRun  <= rdN ? '0 : ((rdLowRun == 16'hFFFF) ? rdLowRun : rdLowRun + 16'd1);
      sinceRead <= !rdN ? '0 : ((sinceRead == 16'hFFFF) ? sinceRead : sinceRead + 16'd1);
    end
  end

  assert_convst_awake_R2: assert property (@(posedge clk) disable iff (!rstN)
    convst |-> wakeOut);

  assert_wake_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convst) |-> (int'(wakeRun) == WAKE_CYC));

  assert_read_length_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdN) |-> (int'(rdLowRun) == RD_CYC));

  assert_select_with_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !csN);

  assert_no_read_in_conversion_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !convst);

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  assert_standby_after_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdN) |-> !wakeOut);

  assert_quiet_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convst) |-> (int'(sinceRead) >= QUIET_CYC));

  assert_timeout_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    errorPulse |-> (!wakeOut && rdN));

endmodule

bind adc_pwr_sequencer adc_pwr_sequencer_chk #(
  .WAKE_CYC (WAKE_CYC),
  .RD_CYC   (RD_EFF),
  .QUIET_CYC(QUIET_CYC)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wakeOut    (wakeOut),
  .convst     (convst),
  .csN        (csN),
  .rdN        (rdN),
  .resultValid(resultValid),
  .errorPulse (errorPulse)
);

// File: tb/adc_pwr_sequencer_bench.sv
module adc_pwr_sequencer_bench;

  localparam int W   = 14;
  localparam int PER = 150;
  localparam int WK  = 20;
  localparam int PL  = 3;
  localparam int TMO = 60;
  localparam int RDC = 5;
  localparam int ACC = 3;
  localparam int QT  = 15;

  localparam int PH_IDLE  = 0;
  localparam int PH_WAKE  = 1;
  localparam int PH_START = 2;
  localparam int PH_CONV  = 3;
  localparam int PH_READ  = 4;
  localparam int PH_QUIET = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rstN;
  logic [1:0]   statusLine;
  logic [W-1:0] dataIn [2];
  logic [1:0]   wakeOut, convst, csN, rdN, resultValid, errorPulse;
  logic [W-1:0] resultData [2];

  adc_pwr_sequencer #(
    .DATA_W(W), .PERIOD_CYC(PER), .WAKE_CYC(WK), .PULSE_CYC(PL), .TIMEOUT_CYC(TMO),
    .RD_CYC(RDC), .ACCESS_CYC(ACC), .QUIET_CYC(QT), .EOC_MODE(1'b0)
  ) u_adc_pwr_sequencer (
    .clk(clk), .rstN(rstN), .statusLine(statusLine[0]), .dataIn(dataIn[0]),
    .wakeOut(wakeOut[0]), .convst(convst[0]), .csN(csN[0]), .rdN(rdN[0]),
    .resultValid(resultValid[0]), .resultData(resultData[0]), .errorPulse(errorPulse[0])
  );

  adc_pwr_sequencer #(
    .DATA_W(W), .PERIOD_CYC(PER), .WAKE_CYC(WK), .PULSE_CYC(PL), .TIMEOUT_CYC(TMO),
    .RD_CYC(RDC), .ACCESS_CYC(ACC), .QUIET_CYC(QT), .EOC_MODE(1'b1)
  ) u_adc_pwr_sequencer_eoc (
    .clk(clk), .rstN(rstN), .statusLine(statusLine[1]), .dataIn(dataIn[1]),
    .wakeOut(wakeOut[1]), .convst(convst[1]), .csN(csN[1]), .rdN(rdN[1]),
    .resultValid(resultValid[1]), .resultData(resultData[1]), .errorPulse(errorPulse[1])
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int inst,
                       input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s inst%0d %s actual=%0d expected=%0d at %0t", tag, inst, what, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] wordFor(input int k, input int idx);
    case (idx % 4)
      0: return '0;
      1: return '1;
      2: return 14'h2AAA;
      default: return W'(idx * 1237 + k * 91);
    endcase
  endfunction

  function automatic int delayFor(input int idx);
    return (idx == 5) ? 56 : 5 + (idx * 7) % 36;
  endfunction

  function automatic bit respondFor(input int k, input int idx);
    return !(idx == 3 || (k == 1 && idx == 6));
  endfunction

  // converter stub state
  int           stTimer [2], lowTimer [2], lowCnt [2], convIdx [2];
  logic         convPrev [2];
  logic [W-1:0] curWord [2];
  logic [W-1:0] expQ0 [$];
  logic [W-1:0] expQ1 [$];

  // reference model state
  int           ph [2], cnt [2], tk [2];
  logic         sPrev [2];
  logic         eValid [2], eErr [2];
  logic [W-1:0] eData [2];
  int           validCnt [2], errCnt [2];

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rstN) begin
        statusLine[k] <= (k == 1);
        dataIn[k]     <= '0;
        stTimer[k] = 0; lowTimer[k] = 0; lowCnt[k] = 0; convIdx[k] = 0;
        convPrev[k] = 1'b0; curWord[k] = '0;
        ph[k] = PH_IDLE; cnt[k] = 0; tk[k] = 0; sPrev[k] = (k == 1);
        eValid[k] = 1'b0; eErr[k] = 1'b0; eData[k] = '0;
      end else begin
        // reference model, fed with the values present before this edge
        begin
          bit tickNow, edgeNow;
          tickNow = (tk[k] == PER - 1);
          tk[k] = tickNow ? 0 : tk[k] + 1;
          edgeNow = (k == 0) ? (sPrev[k] && !statusLine[k]) : (!sPrev[k] && statusLine[k]);
          sPrev[k] = statusLine[k];
          eValid[k] = 1'b0;
          eErr[k] = 1'b0;
          case (ph[k])
            PH_IDLE: if (tickNow) begin ph[k] = PH_WAKE; cnt[k] = 0; end
            PH_WAKE: if (cnt[k] == WK - 1) begin ph[k] = PH_START; cnt[k] = 0; end else cnt[k]++;
            PH_START: if (cnt[k] == PL - 1) begin ph[k] = PH_CONV; cnt[k] = 0; end else cnt[k]++;
            PH_CONV: begin
              if (edgeNow) begin ph[k] = PH_READ; cnt[k] = 0; end
              else if (cnt[k] == TMO - 1) begin ph[k] = PH_IDLE; cnt[k] = 0; eErr[k] = 1'b1; errCnt[k]++; end
              else cnt[k]++;
            end
            PH_READ: begin
              if (cnt[k] == ACC - 1) begin
                eValid[k] = 1'b1;
                validCnt[k]++;
                if (k == 0 && expQ0.size() > 0) eData[k] = expQ0.pop_front();
                else if (k == 1 && expQ1.size() > 0) eData[k] = expQ1.pop_front();
                else check(1'b0, "R7", k, 0, 1, "result without an expected word");
              end
              if (cnt[k] == RDC - 1) begin ph[k] = PH_QUIET; cnt[k] = 0; end else cnt[k]++;
            end
            default: if (cnt[k] == QT - 1) begin ph[k] = PH_IDLE; cnt[k] = 0; end else cnt[k]++;
          endcase
        end
        // converter stub
        if (!rdN[k]) begin
          lowCnt[k]++;
          dataIn[k] <= (lowCnt[k] >= ACC - 1) ? curWord[k] : ~curWord[k];
        end else begin
          lowCnt[k] = 0;
          dataIn[k] <= ~curWord[k];
        end
        if (stTimer[k] > 0) begin
          stTimer[k]--;
          if (stTimer[k] == 0) begin
            statusLine[k] <= 1'b0;
            if (k == 1) lowTimer[k] = 4;
          end
        end else if (lowTimer[k] > 0) begin
          lowTimer[k]--;
          if (lowTimer[k] == 0) statusLine[k] <= 1'b1;
        end else if (convst[k] && !convPrev[k]) begin
          curWord[k] = wordFor(k, convIdx[k]);
          if (respondFor(k, convIdx[k])) begin
            if (k == 0) begin expQ0.push_back(curWord[k]); statusLine[k] <= 1'b1; end
            else expQ1.push_back(curWord[k]);
            stTimer[k] = delayFor(convIdx[k]);
          end
          convIdx[k]++;
        end
        convPrev[k] = convst[k];
      end
    end
  end

  // compare every output against the model away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      for (int k = 0; k < 2; k++) begin
        bit expWake, expConv, expRd;
        expWake = (ph[k] >= PH_WAKE) && (ph[k] <= PH_READ);
        expConv = (ph[k] == PH_START) || (ph[k] == PH_CONV && k == 0);
        expRd   = (ph[k] != PH_READ);
        check(wakeOut[k] == expWake, (ph[k] == PH_QUIET) ? "R8" : "R2", k,
              int'(wakeOut[k]), int'(expWake), "wakeOut");
        check(convst[k] == expConv, (ph[k] == PH_CONV) ? ((k == 0) ? "R4" : "R5") : "R3", k,
              int'(convst[k]), int'(expConv), "convst");
        check(csN[k] == expRd, "R6", k, int'(csN[k]), int'(expRd), "csN");
        check(rdN[k] == expRd, "R6", k, int'(rdN[k]), int'(expRd), "rdN");
        check(resultValid[k] == eValid[k], "R7", k, int'(resultValid[k]), int'(eValid[k]), "resultValid");
        if (eValid[k])
          check(resultData[k] == eData[k], "R7", k, int'(resultData[k]), int'(eData[k]), "resultData");
        check(errorPulse[k] == eErr[k], "R9", k, int'(errorPulse[k]), int'(eErr[k]), "errorPulse");
      end
    end
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired, actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin validCnt[k] = 0; errCnt[k] = 0; end
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state on both instances
    for (int k = 0; k < 2; k++) begin
      check(wakeOut[k] == 1'b0, "R1", k, int'(wakeOut[k]), 0, "wakeOut in reset");
      check(convst[k] == 1'b0, "R1", k, int'(convst[k]), 0, "convst in reset");
      check(csN[k] == 1'b1 && rdN[k] == 1'b1, "R1", k, int'({csN[k], rdN[k]}), 3, "csN,rdN in reset");
      check(resultValid[k] == 1'b0, "R1", k, int'(resultValid[k]), 0, "resultValid in reset");
      check(errorPulse[k] == 1'b0, "R1", k, int'(errorPulse[k]), 0, "errorPulse in reset");
    end
    rstN = 1'b1;
    repeat (13 * PER) @(negedge clk);
    // every answered conversion was read once; unanswered ones timed out (R7, R9)
    check(validCnt[0] == 11, "R7", 0, validCnt[0], 11, "results delivered");
    check(validCnt[1] == 10, "R7", 1, validCnt[1], 10, "results delivered");
    check(errCnt[0] == 1, "R9", 0, errCnt[0], 1, "timeouts");
    check(errCnt[1] == 2, "R9", 1, errCnt[1], 2, "timeouts");
    check(expQ0.size() == 0, "R7", 0, expQ0.size(), 0, "words left unread");
    check(expQ1.size() == 0, "R7", 1, expQ1.size(), 0, "words left unread");
    check(convIdx[0] == 12 && convIdx[1] == 12, "R2", 0, convIdx[0] + convIdx[1], 24, "conversions started");
    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end

endmodule